// File: doc/BRIEF.md
# Pseudorandom RAM Fill Engine

This block loads a 255-word by 8-bit data memory with a deterministic pseudorandom sequence. Software writes a control register with its start bit set. The engine then takes the memory write port and stores one value on every clock cycle, at ascending addresses. It signals completion through a status flag that software can poll.

The values come from an 8-bit linear congruential recurrence, next = 0x11 * cur + 0x9D (mod 256). The first value stored is 0xD7. The sequence restarts from that value on every run, so every fill produces identical memory contents. The multiply by 0x11 reduces to a 4-bit shift plus an add, so no multiplier array is built. While a fill is in progress, the engine holds a bus-request output high so that an external arbiter keeps the processor off the memory port.

Top module: `lcg_ram_filler`

## Requirements
- R1: After reset, `mem_we`, `bus_req` and `fill_done` are all 0.
- R2: A control write (`ctl_wr`=1) with `ctl_wdata` bit 0 = 1 while idle starts a fill. On the next cycle `mem_we`=1, `mem_addr`=0x00 and `mem_wdata`=0xD7.
- R3: Each stored value equals (0x11 * previous value + 0x9D) mod 256, where the previous value is the one stored on the cycle before.
- R4: During a fill, `mem_addr` starts at 0x00 and rises by one every cycle, up to 0xFE.
- R5: A fill asserts `mem_we` on exactly 255 consecutive cycles. `bus_req` is high on exactly those cycles.
- R6: `fill_done` becomes 1 on the cycle after the write to 0xFE, with `mem_we` already 0. It stays 1 until the next control write.
- R7: Any control write clears `fill_done`. A control write with bit 0 = 0 starts no fill.
- R8: A control write with bit 0 = 1 during a fill is ignored. The address and value sequence continues unchanged.
- R9: Every fill restarts from 0xD7 at address 0x00, so successive fills store identical data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write data; bit 0 is the start bit |
| fill_done | output | 1 | Status: fill complete |
| bus_req | output | 1 | Memory port request, high while filling |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 8 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The assertions check the following on every cycle:
- `mem_we` always matches `bus_req`.
- Write addresses advance by one on consecutive write cycles.
- Each value follows the recurrence from the value written before it.
- `fill_done` never coincides with a write.
- A control write always clears a set done flag.

Only the bench scenarios can show the following:
- The full 255-entry contents.
- The exact count of write cycles.
- That a start request made mid-fill leaves the sequence untouched.
- That a second fill repeats the first one's data.

// File: rtl/lcg_ram_filler.sv
module lcg_ram_filler #(
  parameter int W     = 8,
  parameter int DEPTH = 255,
  parameter int MUL_SHIFT = 4,
  parameter logic [7:0] INC  = 8'h9D,
  parameter logic [7:0] SEED = 8'hD7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic [7:0]   ctl_wdata,
  output logic         fill_done,
  output logic         bus_req,
  output logic         mem_we,
  output logic [7:0]   mem_addr,
  output logic [W-1:0] mem_wdata
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy;
  logic [AW-1:0] idx;
  logic [W-1:0]  val;
  logic [W-1:0]  nxt;
  logic          start;

  assign nxt   = W'((val << MUL_SHIFT) + val + W'(INC));
  assign start = ctl_wr && ctl_wdata[0] && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      idx       <= '0;
      val       <= '0;
      fill_done <= 1'b0;
    end else begin
      if (ctl_wr) fill_done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        idx  <= '0;
        val  <= W'(SEED);
      end else if (busy) begin
        idx <= idx + 1'b1;
        val <= nxt;
        if (idx == LAST) begin
          busy      <= 1'b0;
          fill_done <= 1'b1;
        end
      end
    end
  end

  assign bus_req   = busy;
  assign mem_we    = busy;
  assign mem_addr  = 8'(idx);
  assign mem_wdata = val;
endmodule

// File: rtl/lcg_ram_filler_chk.sv
module lcg_ram_filler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic [7:0] ctl_wdata,
  input logic       fill_done,
  input logic       bus_req,
  input logic       mem_we,
  input logic [7:0] mem_addr,
  input logic [7:0] mem_wdata
);
  assert_we_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we == bus_req);

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_addr != 8'hFE |=> mem_we && mem_addr == $past(mem_addr) + 8'd1);

  assert_recur_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_addr != 8'hFE |=>
      mem_wdata == 8'(($past(mem_wdata) << 4) + $past(mem_wdata) + 8'h9D));

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && ctl_wdata[0] && !mem_we |=> mem_we && mem_addr == 8'h00 && mem_wdata == 8'hD7);

  assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_done && mem_we));

  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && mem_addr == 8'hFE |=> fill_done && !mem_we);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr && fill_done |=> !fill_done);
endmodule

bind lcg_ram_filler lcg_ram_filler_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
  .fill_done(fill_done), .bus_req(bus_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/tb_lcg_ram_filler.sv
module tb_lcg_ram_filler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic       fill_done, bus_req, mem_we;
  logic [7:0] mem_addr, mem_wdata;

  int tests = 0;
  int fails = 0;
  logic [7:0] run1 [255];

  localparam logic [15:0] VEC [8] = '{
    16'h00D7, 16'h01E4, 16'h02C1, 16'h036E,
    16'h04EB, 16'h0538, 16'h0655, 16'h0742};

  always #5 clk = ~clk;

  lcg_ram_filler dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .fill_done(fill_done), .bus_req(bus_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ctl(input logic [7:0] d);
    @(negedge clk);
    ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_wdata = 8'h00;
  endtask

  task automatic run_fill(input bit first, input bit poke);
    logic [7:0] model = 8'hD7;
    int wes = 0;
    ctl(8'h01);
    for (int i = 0; i < 255; i++) begin
      if (mem_we) wes++;
      chk("R4 addr", {8'h00, mem_addr}, 16'(i));
      chk("R3 data", {8'h00, mem_wdata}, {8'h00, model});
      if (i < 8) chk("R2 vector", {mem_addr, mem_wdata}, VEC[i]);
      if (first) run1[i] = mem_wdata;
      else chk("R9 repeat", {8'h00, mem_wdata}, {8'h00, run1[i]});
      chk("R5 bus_req", {15'h0, bus_req}, 16'h1);
      model = 8'((model << 4) + model + 8'h9D);
      if (poke && i == 10) begin ctl_wr = 1'b1; ctl_wdata = 8'h01; end
      if (poke && i == 11) begin ctl_wr = 1'b0; ctl_wdata = 8'h00; end
      @(negedge clk);
    end
    chk("R5 we count", 16'(wes), 16'd255);
    chk("R5 we low after", {15'h0, mem_we}, 16'h0);
    chk("R6 done", {15'h0, fill_done}, 16'h1);
    @(negedge clk);
    chk("R8 no restart", {15'h0, mem_we}, 16'h0);
    chk("R6 done held", {15'h0, fill_done}, 16'h1);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 we", {15'h0, mem_we}, 16'h0);
    chk("R1 req", {15'h0, bus_req}, 16'h0);
    chk("R1 done", {15'h0, fill_done}, 16'h0);
    ctl(8'hFE);
    chk("R7 no start", {15'h0, mem_we}, 16'h0);
    run_fill(1'b1, 1'b0);
    ctl(8'h00);
    chk("R7 clear", {15'h0, fill_done}, 16'h0);
    chk("R7 no start bit0=0", {15'h0, mem_we}, 16'h0);
    run_fill(1'b0, 1'b1);
    ctl(8'h80);
    chk("R7 clear any", {15'h0, fill_done}, 16'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule